// File: doc/BRIEF.md
# Maintenance Message Last-Look Filter

This block sits behind the deframer of a digital subscriber line and cleans up the slow maintenance traffic that rides in each 12 ms superframe. Two kinds of information arrive from the line side. The first is an operations message: a 3-bit address, a bit telling a message from numerical data, and an 8-bit information field. A complete message arrives every 6 ms, so two come in each superframe. The second kind is a set of single overhead status bits, one sample of each per superframe, together with a flag that says whether the superframe CRC checked good.

Messages are handled in one of three modes. In echo mode each message goes straight back toward the line and, when it is a command aimed at this terminal, is also raised as a command pulse. In every-message mode each message is handed to the host with an interrupt. In on-change mode the host is interrupted only when a message differs from the one it was last given. Each status bit has its own filter: pass through, three-in-a-row confirmation, or CRC-gated with one superframe of delay. The host sees a message register and a status register, each with its own interrupt flag that a read strobe clears.

Top module: `maint_lastlook_filter`

## Requirements
- R1: After reset, msg_irq, stat_irq, echo_valid and cmd_valid are 0, and msg_data and stat_data are all zeros.
- R2: With msg_mode = 2'b00 (echo), a msg_valid pulse makes echo_valid high for exactly the next cycle with echo_addr, echo_dm and echo_info equal to the received fields; in the other modes echo_valid stays 0. Echo mode never changes msg_data or msg_irq.
- R3: In echo mode cmd_valid pulses in the cycle after msg_valid, with cmd_code equal to the information field, only when the address equals NT_ADDR (default 0) and msg_dm is 1 (message); a different address, msg_dm = 0 or another mode gives no pulse.
- R4: With msg_mode = 2'b01 (every message), each msg_valid loads msg_data = {addr[11:9], dm[8], info[7:0]} and sets msg_irq in the next cycle, even when the word repeats.
- R5: With msg_mode = 2'b10 or 2'b11 (on change), msg_data is loaded and msg_irq set only when the received word differs from the current msg_data; an identical word changes nothing.
- R6: A msg_rd pulse clears msg_irq in the next cycle; if a reportable message arrives in the same cycle, msg_irq stays set.
- R7: A status bit whose 2-bit field in bit_mode (bits [2i+1:2i] for bit i) is 2'b00 or 2'b11 takes the sampled value at each sf_valid.
- R8: A status bit with field 2'b01 takes a new value only at an sf_valid where that value has been sampled in three consecutive superframes, including the current one.
- R9: A status bit with field 2'b10 takes, at each sf_valid, the sample from the previous superframe if that superframe had crc_ok = 1, and otherwise keeps its value.
- R10: stat_irq is set in the cycle after any bit of stat_data changes and is cleared by a stat_rd pulse; a change in the same cycle as stat_rd keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_mode | input | 2 | Message mode: 00 echo, 01 every message, 10/11 on change |
| bit_mode | input | 2*NBITS | Per status bit filter: 00/11 raw, 01 three-look, 10 CRC-gated |
| msg_valid | input | 1 | One-cycle strobe, a complete message is present |
| msg_addr | input | 3 | Received message address |
| msg_dm | input | 1 | 1 = message, 0 = numerical data |
| msg_info | input | 8 | Received information field |
| sf_valid | input | 1 | One-cycle strobe at the end of a superframe |
| ovh_bits | input | NBITS | Overhead status bit samples of this superframe |
| crc_ok | input | 1 | Superframe CRC checked good |
| msg_rd | input | 1 | Host read of msg_data, clears msg_irq |
| stat_rd | input | 1 | Host read of stat_data, clears stat_irq |
| echo_valid | output | 1 | Echo word valid for one cycle |
| echo_addr | output | 3 | Echoed address |
| echo_dm | output | 1 | Echoed data/message bit |
| echo_info | output | 8 | Echoed information field |
| cmd_valid | output | 1 | Command for this terminal, one cycle |
| cmd_code | output | 8 | Command code |
| msg_irq | output | 1 | Message interrupt flag |
| msg_data | output | 12 | Last reported message word |
| stat_irq | output | 1 | Status change interrupt flag |
| stat_data | output | NBITS | Filtered status bits |

## Verification
The hardest situations to reach are the filter windows: a three-look bit that sees a value twice and then loses it, and a CRC-gated bit whose accepting superframe is followed by a bad one, together with host reads that land in the same cycle as a new report. Directed sequences build those windows explicitly, and a long seeded random run then mixes messages, superframes with random CRC flags, mode changes and reads, so that partial runs of two equal samples and mode switches in the middle of a run occur many times against the bench model.

// File: rtl/maint_ll_pkg.sv
package maint_ll_pkg;

    localparam int ADDR_W = 3;
    localparam int INFO_W = 8;
    localparam int WORD_W = ADDR_W + 1 + INFO_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              dm;
        logic [INFO_W-1:0] info;
    } op_word_t;

    typedef enum logic [1:0] {
        MM_ECHO   = 2'b00,
        MM_EVERY  = 2'b01,
        MM_CHANGE = 2'b10,
        MM_CHG_B  = 2'b11
    } msg_mode_e;

    typedef enum logic [1:0] {
        BF_RAW  = 2'b00,
        BF_LOOK = 2'b01,
        BF_CRC  = 2'b10,
        BF_RSV  = 2'b11
    } bit_filt_e;

    function automatic logic is_local_cmd(op_word_t w, logic [ADDR_W-1:0] own);
        return (w.addr == own) && w.dm;
    endfunction

endpackage

// File: rtl/mm_msg_path.sv
module mm_msg_path
    import maint_ll_pkg::*;
#(
    parameter logic [ADDR_W-1:0] NT_ADDR = '0
) (
    input  logic       clk,
    input  logic       rst,
    input  msg_mode_e  mode,
    input  logic       in_valid,
    input  op_word_t   in_word,
    input  logic       rd,
    output logic       echo_valid,
    output op_word_t   echo_word,
    output logic       cmd_valid,
    output logic [INFO_W-1:0] cmd_code,
    output op_word_t   rep_word,
    output logic       rep_irq
);

    logic is_echo;
    logic report_now;

    always_comb begin
        is_echo = (mode == MM_ECHO);
        unique case (mode)
            MM_ECHO:  report_now = 1'b0;
            MM_EVERY: report_now = in_valid;
            default:  report_now = in_valid && (in_word != rep_word);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            echo_valid <= 1'b0;
            echo_word  <= '0;
            cmd_valid  <= 1'b0;
            cmd_code   <= '0;
            rep_word   <= '0;
            rep_irq    <= 1'b0;
        end else begin
            echo_valid <= in_valid && is_echo;
            cmd_valid  <= in_valid && is_echo && is_local_cmd(in_word, NT_ADDR);
            if (in_valid && is_echo) begin
                echo_word <= in_word;
                cmd_code  <= in_word.info;
            end
            if (report_now) begin
                rep_word <= in_word;
                rep_irq  <= 1'b1;
            end else if (rd) begin
                rep_irq  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mm_bit_filter.sv
module mm_bit_filter
    import maint_ll_pkg::*;
#(
    parameter int LOOKS = 3,
    localparam int CW = $clog2(LOOKS + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  bit_filt_e sel,
    input  logic      sample_en,
    input  logic      bit_in,
    input  logic      crc_ok,
    output logic      bit_q,
    output logic      bit_nxt
);

    logic          cand;
    logic [CW-1:0] run;
    logic [CW-1:0] run_nxt;
    logic          pend;
    logic          pend_v;
    logic          look_hit;

    always_comb begin
        if (run != '0 && bit_in == cand)
            run_nxt = (run == CW'(LOOKS)) ? run : run + CW'(1);
        else
            run_nxt = CW'(1);
        look_hit = (run_nxt == CW'(LOOKS));

        bit_nxt = bit_q;
        if (sample_en) begin
            unique case (sel)
                BF_LOOK: if (look_hit) bit_nxt = bit_in;
                BF_CRC:  if (pend_v)   bit_nxt = pend;
                default: bit_nxt = bit_in;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cand   <= 1'b0;
            run    <= '0;
            pend   <= 1'b0;
            pend_v <= 1'b0;
            bit_q  <= 1'b0;
        end else begin
            bit_q <= bit_nxt;
            if (sample_en) begin
                cand   <= bit_in;
                run    <= run_nxt;
                pend   <= bit_in;
                pend_v <= crc_ok;
            end
        end
    end

endmodule

// File: rtl/maint_lastlook_filter.sv
module maint_lastlook_filter
    import maint_ll_pkg::*;
#(
    parameter int NBITS = 4,
    parameter int LOOKS = 3,
    parameter logic [2:0] NT_ADDR = 3'd0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         msg_mode,
    input  logic [2*NBITS-1:0] bit_mode,
    input  logic               msg_valid,
    input  logic [2:0]         msg_addr,
    input  logic               msg_dm,
    input  logic [7:0]         msg_info,
    input  logic               sf_valid,
    input  logic [NBITS-1:0]   ovh_bits,
    input  logic               crc_ok,
    input  logic               msg_rd,
    input  logic               stat_rd,
    output logic               echo_valid,
    output logic [2:0]         echo_addr,
    output logic               echo_dm,
    output logic [7:0]         echo_info,
    output logic               cmd_valid,
    output logic [7:0]         cmd_code,
    output logic               msg_irq,
    output logic [11:0]        msg_data,
    output logic               stat_irq,
    output logic [NBITS-1:0]   stat_data
);

    op_word_t         in_word;
    op_word_t         echo_word;
    op_word_t         rep_word;
    logic [NBITS-1:0] stat_nxt;

    assign in_word = '{addr: msg_addr, dm: msg_dm, info: msg_info};

    mm_msg_path #(.NT_ADDR(NT_ADDR)) u_msg (
        .clk        (clk),
        .rst        (rst),
        .mode       (msg_mode_e'(msg_mode)),
        .in_valid   (msg_valid),
        .in_word    (in_word),
        .rd         (msg_rd),
        .echo_valid (echo_valid),
        .echo_word  (echo_word),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .rep_word   (rep_word),
        .rep_irq    (msg_irq)
    );

    assign echo_addr = echo_word.addr;
    assign echo_dm   = echo_word.dm;
    assign echo_info = echo_word.info;
    assign msg_data  = rep_word;

    for (genvar g = 0; g < NBITS; g++) begin : g_bit
        mm_bit_filter #(.LOOKS(LOOKS)) u_filt (
            .clk       (clk),
            .rst       (rst),
            .sel       (bit_filt_e'(bit_mode[2*g +: 2])),
            .sample_en (sf_valid),
            .bit_in    (ovh_bits[g]),
            .crc_ok    (crc_ok),
            .bit_q     (stat_data[g]),
            .bit_nxt   (stat_nxt[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            stat_irq <= 1'b0;
        else if (stat_nxt != stat_data)
            stat_irq <= 1'b1;
        else if (stat_rd)
            stat_irq <= 1'b0;
    end

endmodule

// File: rtl/maint_lastlook_filter_chk.sv
module maint_lastlook_filter_chk #(
    parameter int NBITS = 4,
    parameter logic [2:0] NT_ADDR = 3'd0
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       msg_mode,
    input logic             msg_valid,
    input logic [2:0]       msg_addr,
    input logic             msg_dm,
    input logic [7:0]       msg_info,
    input logic             sf_valid,
    input logic             msg_rd,
    input logic             echo_valid,
    input logic [2:0]       echo_addr,
    input logic [7:0]       echo_info,
    input logic             cmd_valid,
    input logic             msg_irq,
    input logic [11:0]      msg_data,
    input logic             stat_irq,
    input logic [NBITS-1:0] stat_data
);

    p_echo_follows_r2: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_mode == 2'b00) |=>
            (echo_valid && echo_addr == $past(msg_addr) && echo_info == $past(msg_info)));

    p_no_echo_r2: assert property (@(posedge clk) disable iff (rst)
        !(msg_valid && msg_mode == 2'b00) |=> !echo_valid);

    p_cmd_target_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> ($past(msg_addr) == NT_ADDR && $past(msg_dm) && $past(msg_valid)));

    p_msg_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !msg_valid |=> $stable(msg_data));

    p_rd_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (msg_rd && !msg_valid) |=> !msg_irq);

    p_stat_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !sf_valid |=> $stable(stat_data));

    p_stat_flag_r10: assert property (@(posedge clk) disable iff (rst)
        (stat_data != $past(stat_data)) |-> stat_irq);

endmodule

bind maint_lastlook_filter maint_lastlook_filter_chk #(.NBITS(NBITS), .NT_ADDR(NT_ADDR)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .msg_mode   (msg_mode),
    .msg_valid  (msg_valid),
    .msg_addr   (msg_addr),
    .msg_dm     (msg_dm),
    .msg_info   (msg_info),
    .sf_valid   (sf_valid),
    .msg_rd     (msg_rd),
    .echo_valid (echo_valid),
    .echo_addr  (echo_addr),
    .echo_info  (echo_info),
    .cmd_valid  (cmd_valid),
    .msg_irq    (msg_irq),
    .msg_data   (msg_data),
    .stat_irq   (stat_irq),
    .stat_data  (stat_data)
);

// File: tb/maint_lastlook_filter_bench.sv
module maint_lastlook_filter_bench;

    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    msg_mode = 2'b00;
    logic [2*NB-1:0] bit_mode = '0;
    logic          msg_valid = 1'b0;
    logic [2:0]    msg_addr = '0;
    logic          msg_dm = 1'b0;
    logic [7:0]    msg_info = '0;
    logic          sf_valid = 1'b0;
    logic [NB-1:0] ovh_bits = '0;
    logic          crc_ok = 1'b0;
    logic          msg_rd = 1'b0;
    logic          stat_rd = 1'b0;
    logic          echo_valid;
    logic [2:0]    echo_addr;
    logic          echo_dm;
    logic [7:0]    echo_info;
    logic          cmd_valid;
    logic [7:0]    cmd_code;
    logic          msg_irq;
    logic [11:0]   msg_data;
    logic          stat_irq;
    logic [NB-1:0] stat_data;

    int checks = 0;
    int errors = 0;

    // bench model
    logic [11:0]   e_data = '0;
    logic          e_irq = 1'b0;
    logic [NB-1:0] e_stat = '0;
    logic          e_sirq = 1'b0;
    logic [NB-1:0] h0 = '0, h1 = '0, h2 = '0;
    int            hcount = 0;
    logic [NB-1:0] prev_s = '0;
    logic          prev_ok = 1'b0;

    always #2.5 clk = ~clk;

    maint_lastlook_filter #(.NBITS(NB)) u_maint_lastlook_filter (
        .clk(clk), .rst(rst), .msg_mode(msg_mode), .bit_mode(bit_mode),
        .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_dm(msg_dm), .msg_info(msg_info),
        .sf_valid(sf_valid), .ovh_bits(ovh_bits), .crc_ok(crc_ok),
        .msg_rd(msg_rd), .stat_rd(stat_rd),
        .echo_valid(echo_valid), .echo_addr(echo_addr), .echo_dm(echo_dm), .echo_info(echo_info),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .msg_irq(msg_irq), .msg_data(msg_data),
        .stat_irq(stat_irq), .stat_data(stat_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [NB-1:0] filt_bits(input logic [NB-1:0] cur, input logic [NB-1:0] s,
                                                input logic [2*NB-1:0] modes);
        logic [NB-1:0] r = cur;
        for (int i = 0; i < NB; i++) begin
            case (modes[2*i +: 2])
                2'b01: if (hcount >= 3 && h0[i] == h1[i] && h1[i] == h2[i]) r[i] = h0[i];
                2'b10: if (prev_ok) r[i] = prev_s[i];
                default: r[i] = s[i];
            endcase
        end
        return r;
    endfunction

    task automatic check_msg_side(input string tag);
        chk({tag, " msg_irq"}, 32'(msg_irq), 32'(e_irq));
        chk({tag, " msg_data"}, 32'(msg_data), 32'(e_data));
    endtask

    task automatic send_msg(input logic [2:0] a, input logic d, input logic [7:0] inf, input logic rd);
        logic [11:0] w = {a, d, inf};
        @(negedge clk);
        msg_valid = 1'b1; msg_addr = a; msg_dm = d; msg_info = inf; msg_rd = rd;
        if (msg_mode == 2'b01 || (msg_mode[1] && w != e_data)) begin
            e_data = w; e_irq = 1'b1;
        end else if (rd) e_irq = 1'b0;
        @(negedge clk);
        msg_valid = 1'b0; msg_rd = 1'b0;
        if (msg_mode == 2'b00) begin
            chk("R2 echo_valid", 32'(echo_valid), 32'd1);
            chk("R2 echo word", {echo_addr, echo_dm, echo_info}, 32'(w));
            chk("R3 cmd_valid", 32'(cmd_valid), 32'(a == 3'd0 && d));
            if (a == 3'd0 && d) chk("R3 cmd_code", 32'(cmd_code), 32'(inf));
        end else begin
            chk("R2 no echo", 32'(echo_valid), 32'd0);
            chk("R3 no cmd", 32'(cmd_valid), 32'd0);
        end
        check_msg_side(msg_mode == 2'b01 ? "R4" : (msg_mode == 2'b00 ? "R2" : "R5"));
    endtask

    task automatic read_msg();
        @(negedge clk);
        msg_rd = 1'b1;
        @(negedge clk);
        msg_rd = 1'b0;
        e_irq = 1'b0;
        chk("R6 msg_irq cleared", 32'(msg_irq), 32'd0);
    endtask

    task automatic read_stat();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        e_sirq = 1'b0;
        chk("R10 stat_irq cleared", 32'(stat_irq), 32'd0);
    endtask

    task automatic superframe(input logic [NB-1:0] s, input logic ok, input logic rd);
        logic [NB-1:0] nxt;
        h2 = h1; h1 = h0; h0 = s;
        if (hcount < 3) hcount++;
        nxt = filt_bits(e_stat, s, bit_mode);
        if (nxt != e_stat) e_sirq = 1'b1;
        else if (rd) e_sirq = 1'b0;
        e_stat = nxt;
        prev_s = s; prev_ok = ok;
        @(negedge clk);
        sf_valid = 1'b1; ovh_bits = s; crc_ok = ok; stat_rd = rd;
        @(negedge clk);
        sf_valid = 1'b0; stat_rd = 1'b0;
        chk("R7/R8/R9 stat_data", 32'(stat_data), 32'(e_stat));
        chk("R10 stat_irq", 32'(stat_irq), 32'(e_sirq));
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 msg_irq", 32'(msg_irq), 32'd0);
        chk("R1 stat_irq", 32'(stat_irq), 32'd0);
        chk("R1 msg_data", 32'(msg_data), 32'd0);
        chk("R1 stat_data", 32'(stat_data), 32'd0);
        chk("R1 echo_valid", 32'(echo_valid), 32'd0);
        chk("R1 cmd_valid", 32'(cmd_valid), 32'd0);

        // R2, R3 echo mode
        msg_mode = 2'b00;
        send_msg(3'd0, 1'b1, 8'h55, 1'b0);
        send_msg(3'd5, 1'b1, 8'h12, 1'b0);
        send_msg(3'd0, 1'b0, 8'h34, 1'b0);
        @(negedge clk);
        chk("R2 echo one cycle", 32'(echo_valid), 32'd0);

        // R4 every message, repeated word
        msg_mode = 2'b01;
        send_msg(3'd2, 1'b1, 8'hA0, 1'b0);
        read_msg();
        send_msg(3'd2, 1'b1, 8'hA0, 1'b0);
        read_msg();

        // R5 on change
        msg_mode = 2'b10;
        send_msg(3'd2, 1'b1, 8'hA0, 1'b0);
        chk("R5 same word no irq", 32'(msg_irq), 32'd0);
        send_msg(3'd2, 1'b1, 8'hA1, 1'b0);
        chk("R5 new word irq", 32'(msg_irq), 32'd1);
        // R6 read in same cycle as a new report
        send_msg(3'd3, 1'b0, 8'hA1, 1'b1);
        chk("R6 set wins over read", 32'(msg_irq), 32'd1);
        read_msg();
        msg_mode = 2'b11;
        send_msg(3'd3, 1'b0, 8'hA1, 1'b0);
        chk("R5 alt code same word", 32'(msg_irq), 32'd0);

        // R7 raw bit0, R8 look bit1 and bit3, R9 crc bit2
        bit_mode = {2'b01, 2'b10, 2'b01, 2'b00};
        superframe(4'b0011, 1'b0, 1'b0);
        superframe(4'b0010, 1'b0, 1'b0);
        chk("R8 two looks not enough", 32'(stat_data[1]), 32'd0);
        superframe(4'b1010, 1'b1, 1'b0);
        chk("R8 third look accepted", 32'(stat_data[1]), 32'd1);
        chk("R9 bad crc sample ignored", 32'(stat_data[2]), 32'd0);
        superframe(4'b1100, 1'b0, 1'b0);
        chk("R9 delayed by one superframe", 32'(stat_data[2]), 32'd0);
        superframe(4'b1100, 1'b1, 1'b0);
        superframe(4'b1000, 1'b0, 1'b0);
        chk("R9 good crc sample delivered", 32'(stat_data[2]), 32'd1);
        chk("R8 bit3 three looks", 32'(stat_data[3]), 32'd1);
        read_stat();
        superframe(4'b1000, 1'b0, 1'b1);
        chk("R10 no change no flag", 32'(stat_irq), 32'd0);
        bit_mode = {2'b11, 2'b11, 2'b11, 2'b11};
        superframe(4'b0101, 1'b0, 1'b1);
        chk("R7 reserved code raw", 32'(stat_data), 32'h5);
        chk("R10 change beats read", 32'(stat_irq), 32'd1);

        // seeded random mix
        for (int k = 0; k < 1500; k++) begin
            int op = $urandom_range(0, 9);
            if ($urandom_range(0, 19) == 0) msg_mode = 2'($urandom);
            if ($urandom_range(0, 29) == 0) bit_mode = (2*NB)'($urandom);
            if (op < 4) begin
                logic [2:0] a = ($urandom_range(0, 1) == 0) ? 3'd0 : 3'($urandom);
                logic [7:0] inf = ($urandom_range(0, 2) == 0) ? e_data[7:0] : 8'($urandom);
                send_msg(a, 1'($urandom), inf, 1'($urandom_range(0, 3) == 0));
            end else if (op < 8) begin
                logic [NB-1:0] s = ($urandom_range(0, 1) == 0) ? h0 : NB'($urandom);
                superframe(s, 1'($urandom), 1'($urandom_range(0, 3) == 0));
            end else if (op == 8) begin
                read_msg();
            end else begin
                read_stat();
            end
        end
        finish_run();
    end

endmodule